// File: doc/BRIEF.md
# Linear CCD Line Timer

This block turns a fast master clock into the complete set of drive waveforms for a four-row linear colour CCD. Each line opens with a guarded shift-gate window. A lead interval holds transfer phase 1 high, then the shift gate itself is high, and a trail interval keeps phase 1 high again. After the window the line runs a fixed number of pixel periods. In each pixel period the two transfer phases toggle in opposite senses, a reset pulse is issued, and a clamp pulse and an ADC sample strobe follow.

Every width and offset is a count of fast-clock ticks taken from live configuration inputs. The pixel-level settings, the window settings and the clamp style are captured once per line, in the cycle before that line begins. The output mode (colour or black-and-white) is sampled at a programmable tick inside the shift-gate pulse. The new switch levels therefore appear while the gate is high, and the pixel count of that line follows the new mode. When the run enable drops, the current line always finishes before the block goes idle.

Top module: `ccd_line_timer`

## Requirements
- R1: After reset, and while idle, phase 1 is high, phase 2 is low, and the shift gate, reset, clamp, line strobe and sample strobe are low. The mode is colour: switch 1 is high and switch 2 is low.
- R2: A line is leadTicks ticks with the gate low, then sgTicks ticks with the gate high, then trailTicks ticks with the gate low, then the pixel periods. The next line follows with no gap while running. lineStrobe is high only in the first gate-high tick.
- R3: Inside pixel tick k (0 to pixTicks-1), phase 1 is high exactly when k < floor(pixTicks/2), and phase 2 is its complement. During the lead, gate and trail intervals phase 1 is high and phase 2 is low.
- R4: The reset pulse is high in pixel ticks k < rstTicks and is never high outside the pixel periods.
- R5: In bit-clamp mode (lineClamp=0) the clamp is high in pixel ticks clampOffset <= k < clampOffset+clampTicks and is low in the lead, gate and trail intervals.
- R6: In line-clamp mode (lineClamp=1) with clampHold=1, the clamp is high for the whole line. With clampHold=0 the clamp equals the shift gate.
- R7: The sample strobe is high for exactly one tick per pixel, at k = clampOffset+clampTicks+sampleDelay, provided that tick lies inside the pixel period.
- R8: A colour line has COLOR_LINE_PIX pixel periods and a black-and-white line has MONO_LINE_PIX.
- R9: colorMode=1 gives switch 1 high and switch 2 low; colorMode=0 gives the reverse. colorMode is sampled at gate tick swDelay and the switches change one tick later, with swDelay+1 < sgTicks. A change at any other time has no effect until then.
- R10: All tick counts, lineClamp and clampHold are captured in the cycle before a line's lead interval starts. Changing them mid-line does not alter the current line.
- R11: When runEn is low at the end of a line, the block enters the idle state of R1 and keeps the current mode. runEn low mid-line does not shorten the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast master clock |
| rstN | input | 1 | active-low asynchronous reset |
| runEn | input | 1 | start and keep running lines |
| colorMode | input | 1 | 1 colour, 0 black-and-white |
| lineClamp | input | 1 | 1 line clamp, 0 bit clamp |
| clampHold | input | 1 | line clamp style: 1 held high, 0 follows gate |
| pixTicks | input | CNT_W | ticks per pixel period (at least 2) |
| rstTicks | input | CNT_W | reset pulse width |
| clampOffset | input | CNT_W | clamp start tick inside a pixel |
| clampTicks | input | CNT_W | clamp width |
| sampleDelay | input | CNT_W | ticks from clamp end to sample strobe |
| leadTicks | input | CNT_W | phase 1 lead before gate (at least 1) |
| sgTicks | input | CNT_W | shift-gate width (at least 1) |
| trailTicks | input | CNT_W | phase 1 hold after gate (at least 1) |
| swDelay | input | CNT_W | gate tick at which mode is applied |
| sgPulse | output | 1 | shift-gate pulse |
| phi1 | output | 1 | transfer clock phase 1 |
| phi2 | output | 1 | transfer clock phase 2 |
| rstPulse | output | 1 | per-pixel reset pulse |
| clampPulse | output | 1 | clamp pulse |
| sw1 | output | 1 | mode switch 1 |
| sw2 | output | 1 | mode switch 2 |
| lineStrobe | output | 1 | one tick at shift-gate rise |
| sampleStrobe | output | 1 | ADC sample strobe |

## Verification
A wrong pixel-tick counter shows in phase 1, the reset pulse and the sample strobe within one pixel period. A miscounted pixel index or a wrong line length moves the next shift-gate rise and the line strobe, which the bench sees at the first line boundary. A mode or clamp style applied at the wrong moment shows as switch levels changing outside the gate, or as clamp behaviour differing from the captured setting in the lead interval of the next line. Every output is compared on every tick against an arithmetic model of the line timeline, over sweeps of pixel width and clamp style, with configuration changed mid-line.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_GATE  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_PIX   = 3'd4
  } seqState_t;

  // strobes from sequence control to the pulse datapath
  typedef struct packed {
    logic inLead;
    logic inGate;
    logic gateFirst;
    logic inTrail;
    logic pixRun;
    logic loadCfg;
  } ctlStrb_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_timing_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int COLOR_LINE_PIX = 5490,
  parameter int MONO_LINE_PIX  = 2745
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             colorMode,
  input  logic [CNT_W-1:0] leadTicks,
  input  logic [CNT_W-1:0] sgTicks,
  input  logic [CNT_W-1:0] trailTicks,
  input  logic [CNT_W-1:0] swDelay,
  input  logic             pixWrap,
  output ctlStrb_t         strb,
  output logic             activeColor
);

  localparam int MAX_PIX = (COLOR_LINE_PIX > MONO_LINE_PIX) ? COLOR_LINE_PIX : MONO_LINE_PIX;
  localparam int PIX_W   = $clog2(MAX_PIX + 1);
  localparam logic [PIX_W-1:0] COLOR_LAST = PIX_W'(COLOR_LINE_PIX - 1);
  localparam logic [PIX_W-1:0] MONO_LAST  = PIX_W'(MONO_LINE_PIX - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  seqState_t        state;
  logic [CNT_W-1:0] tickCnt;
  logic [PIX_W-1:0] pixCnt;
  logic [CNT_W-1:0] shLead, shSg, shTrail, shSw;
  logic [PIX_W-1:0] lastPix;
  logic             lineEnd;
  logic             startLine;
  logic             applyMode;

  always_comb begin
    lastPix   = activeColor ? COLOR_LAST : MONO_LAST;
    lineEnd   = (state == ST_PIX) && pixWrap && (pixCnt == lastPix);
    startLine = runEn && ((state == ST_IDLE) || lineEnd);
    applyMode = (state == ST_GATE) && (tickCnt == shSw);
    strb.inLead    = (state == ST_LEAD);
    strb.inGate    = (state == ST_GATE);
    strb.gateFirst = (state == ST_GATE) && (tickCnt == '0);
    strb.inTrail   = (state == ST_TRAIL);
    strb.pixRun    = (state == ST_PIX);
    strb.loadCfg   = startLine;
  end

  // window settings are captured once per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shLead  <= ONE;
      shSg    <= ONE;
      shTrail <= ONE;
      shSw    <= '0;
    end else if (startLine) begin
      shLead  <= leadTicks;
      shSg    <= sgTicks;
      shTrail <= trailTicks;
      shSw    <= swDelay;
    end
  end

  // mode switches change only inside the gate pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeColor <= 1'b1;
    else if (applyMode) activeColor <= colorMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      pixCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          pixCnt  <= '0;
          if (runEn) state <= ST_LEAD;
        end
        ST_LEAD: begin
          if (tickCnt == shLead - ONE) begin
            state   <= ST_GATE;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + ONE;
        end
        ST_GATE: begin
          if (tickCnt == shSg - ONE) begin
            state   <= ST_TRAIL;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + ONE;
        end
        ST_TRAIL: begin
          if (tickCnt == shTrail - ONE) begin
            state   <= ST_PIX;
            tickCnt <= '0;
            pixCnt  <= '0;
          end else tickCnt <= tickCnt + ONE;
        end
        ST_PIX: begin
          if (pixWrap) begin
            if (pixCnt == lastPix) begin
              state   <= runEn ? ST_LEAD : ST_IDLE;
              tickCnt <= '0;
              pixCnt  <= '0;
            end else pixCnt <= pixCnt + PIX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: pixel index never passes the line length of the active mode
  a_r8_pix_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PIX) |-> (pixCnt <= lastPix));

  // R11: idle is entered only from the last tick of a line
  a_r11_idle_at_line_end: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && ($past(state) != ST_IDLE)) |-> $past(lineEnd));

endmodule

// File: rtl/ccd_pulse_dp.sv
module ccd_pulse_dp
  import ccd_timing_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic             activeColor,
  input  logic             lineClamp,
  input  logic             clampHold,
  input  logic [CNT_W-1:0] pixTicks,
  input  logic [CNT_W-1:0] rstTicks,
  input  logic [CNT_W-1:0] clampOffset,
  input  logic [CNT_W-1:0] clampTicks,
  input  logic [CNT_W-1:0] sampleDelay,
  output logic             pixWrap,
  output logic             sgOut,
  output logic             phi1Out,
  output logic             phi2Out,
  output logic             rstOut,
  output logic             cpOut,
  output logic             sw1Out,
  output logic             sw2Out,
  output logic             lineStrb,
  output logic             smpStrb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] shP, shRst, shCo, shCw, shSd;
  logic             shLc, shHold;
  logic [CNT_W-1:0] pixTick;
  logic [CNT_W-1:0] halfP;
  logic [CNT_W:0]   cpEnd;
  logic [CNT_W+1:0] smpAt;
  logic             windowed;
  logic             pixPhi1;
  logic             bitCp;
  logic             lineCp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shP    <= CNT_W'(2);
      shRst  <= '0;
      shCo   <= '0;
      shCw   <= '0;
      shSd   <= '0;
      shLc   <= 1'b0;
      shHold <= 1'b0;
    end else if (strb.loadCfg) begin
      shP    <= pixTicks;
      shRst  <= rstTicks;
      shCo   <= clampOffset;
      shCw   <= clampTicks;
      shSd   <= sampleDelay;
      shLc   <= lineClamp;
      shHold <= clampHold;
    end
  end

  always_comb pixWrap = strb.pixRun && (pixTick == shP - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixTick <= '0;
    else if (!strb.pixRun || pixWrap) pixTick <= '0;
    else pixTick <= pixTick + ONE;
  end

  always_comb begin
    windowed = strb.inLead || strb.inGate || strb.inTrail;
    halfP    = shP >> 1;
    cpEnd    = {1'b0, shCo} + {1'b0, shCw};
    smpAt    = {1'b0, cpEnd} + {2'b00, shSd};
    pixPhi1  = pixTick < halfP;
    bitCp    = strb.pixRun && (pixTick >= shCo) && ({1'b0, pixTick} < cpEnd);
    lineCp   = (windowed && (shHold || strb.inGate)) || (strb.pixRun && shHold);

    sgOut    = strb.inGate;
    lineStrb = strb.gateFirst;
    phi1Out  = strb.pixRun ? pixPhi1 : 1'b1;
    phi2Out  = strb.pixRun && !pixPhi1;
    rstOut   = strb.pixRun && (pixTick < shRst);
    cpOut    = shLc ? lineCp : bitCp;
    smpStrb  = strb.pixRun && ({2'b00, pixTick} == smpAt);
    sw1Out   = activeColor;
    sw2Out   = !activeColor;
  end

  // R4: no reset pulse inside the shift-gate window
  a_r4_no_reset_in_window: assert property (@(posedge clk) disable iff (!rstN)
    windowed |-> !rstOut);

  // R3: phase 1 stays high through the gate pulse
  a_r3_phi1_over_gate: assert property (@(posedge clk) disable iff (!rstN)
    strb.inGate |-> phi1Out);

  // R7: in bit clamp the sample never overlaps the clamp
  a_r7_sample_after_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (smpStrb && !shLc) |-> !cpOut);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timing_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int COLOR_LINE_PIX = 5490,
  parameter int MONO_LINE_PIX  = 2745
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             colorMode,
  input  logic             lineClamp,
  input  logic             clampHold,
  input  logic [CNT_W-1:0] pixTicks,
  input  logic [CNT_W-1:0] rstTicks,
  input  logic [CNT_W-1:0] clampOffset,
  input  logic [CNT_W-1:0] clampTicks,
  input  logic [CNT_W-1:0] sampleDelay,
  input  logic [CNT_W-1:0] leadTicks,
  input  logic [CNT_W-1:0] sgTicks,
  input  logic [CNT_W-1:0] trailTicks,
  input  logic [CNT_W-1:0] swDelay,
  output logic             sgPulse,
  output logic             phi1,
  output logic             phi2,
  output logic             rstPulse,
  output logic             clampPulse,
  output logic             sw1,
  output logic             sw2,
  output logic             lineStrobe,
  output logic             sampleStrobe
);

  ctlStrb_t strb;
  logic     activeColor;
  logic     pixWrap;

  ccd_seq_ctrl #(
    .CNT_W          (CNT_W),
    .COLOR_LINE_PIX (COLOR_LINE_PIX),
    .MONO_LINE_PIX  (MONO_LINE_PIX)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .runEn       (runEn),
    .colorMode   (colorMode),
    .leadTicks   (leadTicks),
    .sgTicks     (sgTicks),
    .trailTicks  (trailTicks),
    .swDelay     (swDelay),
    .pixWrap     (pixWrap),
    .strb        (strb),
    .activeColor (activeColor)
  );

  ccd_pulse_dp #(
    .CNT_W (CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .activeColor (activeColor),
    .lineClamp   (lineClamp),
    .clampHold   (clampHold),
    .pixTicks    (pixTicks),
    .rstTicks    (rstTicks),
    .clampOffset (clampOffset),
    .clampTicks  (clampTicks),
    .sampleDelay (sampleDelay),
    .pixWrap     (pixWrap),
    .sgOut       (sgPulse),
    .phi1Out     (phi1),
    .phi2Out     (phi2),
    .rstOut      (rstPulse),
    .cpOut       (clampPulse),
    .sw1Out      (sw1),
    .sw2Out      (sw2),
    .lineStrb    (lineStrobe),
    .smpStrb     (sampleStrobe)
  );

  // R9: mode switch levels move only while the gate is high
  a_r9_switch_in_gate: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sw1) |-> sgPulse);

  // R2: the line strobe marks the gate rising edge
  a_r2_strobe_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    lineStrobe |-> $rose(sgPulse));

endmodule

// File: tb/ccd_line_timer_tb.sv
module ccd_line_timer_tb_top;

  localparam int CW   = 8;
  localparam int CPIX = 12;
  localparam int MPIX = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, colorMode = 1'b1, lineClamp = 1'b0, clampHold = 1'b0;
  logic [CW-1:0] pixTicks = 8'd6, rstTicks = 8'd1, clampOffset = 8'd2, clampTicks = 8'd2;
  logic [CW-1:0] sampleDelay = 8'd1, leadTicks = 8'd2, sgTicks = 8'd5, trailTicks = 8'd3;
  logic [CW-1:0] swDelay = 8'd1;
  logic sgPulse, phi1, phi2, rstPulse, clampPulse, sw1, sw2, lineStrobe, sampleStrobe;

  always #10 clk = ~clk;

  ccd_line_timer #(.CNT_W(CW), .COLOR_LINE_PIX(CPIX), .MONO_LINE_PIX(MPIX)) dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .colorMode(colorMode),
    .lineClamp(lineClamp), .clampHold(clampHold), .pixTicks(pixTicks),
    .rstTicks(rstTicks), .clampOffset(clampOffset), .clampTicks(clampTicks),
    .sampleDelay(sampleDelay), .leadTicks(leadTicks), .sgTicks(sgTicks),
    .trailTicks(trailTicks), .swDelay(swDelay), .sgPulse(sgPulse), .phi1(phi1),
    .phi2(phi2), .rstPulse(rstPulse), .clampPulse(clampPulse), .sw1(sw1),
    .sw2(sw2), .lineStrobe(lineStrobe), .sampleStrobe(sampleStrobe));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string scen = "R1";

  // bench model of the line timeline
  bit mIdle = 1, mColor = 1, mLc = 0, mHold = 0;
  int mO = 0, mLines = 0;
  int mA, mW, mB, mP, mRst, mCo, mCw, mSd, mSw;

  task automatic chk(string what, string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s scen=%s off=%0d idle=%0b actual=%0b expected=%0b",
               req, what, scen, mO, mIdle, act, exp);
    end
  endtask

  task automatic loadModelCfg();
    mA = leadTicks; mW = sgTicks; mB = trailTicks; mP = pixTicks;
    mRst = rstTicks; mCo = clampOffset; mCw = clampTicks; mSd = sampleDelay;
    mSw = swDelay; mLc = lineClamp; mHold = clampHold;
  endtask

  task automatic tick();
    logic eSg, ePhi1, ePhi2, eRs, eCp, eLs, eSmp;
    int lineLen;
    eSg = 0; ePhi1 = 1; ePhi2 = 0; eRs = 0; eCp = 0; eLs = 0; eSmp = 0;
    if (!mIdle) begin
      if (mO < mA + mW + mB) begin
        eSg = (mO >= mA) && (mO < mA + mW);
        eLs = (mO == mA);
        eCp = mLc && (mHold || eSg);
      end else begin
        int k;
        k = (mO - mA - mW - mB) % mP;
        ePhi1 = (k < mP / 2);
        ePhi2 = !ePhi1;
        eRs = (k < mRst);
        eCp = mLc ? mHold : ((k >= mCo) && (k < mCo + mCw));
        eSmp = (k == mCo + mCw + mSd);
      end
    end
    if (mIdle) begin
      // R1 R11 idle levels
      chk("phi1", "R1 R11", phi1, 1'b1);
      chk("phi2", "R1 R11", phi2, 1'b0);
      chk("sg", "R1 R11", sgPulse, 1'b0);
      chk("rst", "R1 R11", rstPulse, 1'b0);
      chk("clamp", "R1 R11", clampPulse, 1'b0);
      chk("sample", "R1 R11", sampleStrobe, 1'b0);
      chk("strobe", "R1 R11", lineStrobe, 1'b0);
    end else begin
      chk("sg", "R2 R8 R10", sgPulse, eSg);
      chk("strobe", "R2", lineStrobe, eLs);
      chk("phi1", "R3", phi1, ePhi1);
      chk("phi2", "R3", phi2, ePhi2);
      chk("rst", "R4", rstPulse, eRs);
      chk("clamp", mLc ? "R6 R10" : "R5 R10", clampPulse, eCp);
      chk("sample", "R7", sampleStrobe, eSmp);
    end
    chk("sw1", "R9", sw1, mColor);
    chk("sw2", "R9", sw2, !mColor);
    // advance the model across the coming edge
    if (mIdle) begin
      if (runEn) begin
        loadModelCfg();
        mIdle = 0;
        mO = 0;
      end
    end else begin
      if (mO == mA + mSw) mColor = colorMode;
      lineLen = mA + mW + mB + (mColor ? CPIX : MPIX) * mP;
      if (mO == lineLen - 1) begin
        mLines++;
        mO = 0;
        if (runEn) loadModelCfg();
        else mIdle = 1;
      end else mO++;
    end
    @(negedge clk);
  endtask

  task automatic runLines(int n);
    int target;
    target = mLines + n;
    while (mLines < target) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    scen = "R1";
    repeat (6) tick();
    // R2..R8: colour, bit clamp
    scen = "R2";
    runEn = 1'b1;
    runLines(2);
    // R9: mode change requested mid-line
    scen = "R9";
    repeat (5) tick();
    colorMode = 1'b0;
    runLines(3);
    // R10 R5 R6: sweep pixel width and clamp style, changed mid-line
    for (int p = 2; p <= 8; p++) begin
      for (int cm = 0; cm < 3; cm++) begin
        scen = "R10";
        repeat (3) tick();
        pixTicks    = CW'(p);
        rstTicks    = CW'(1 + (p > 5 ? 1 : 0));
        clampOffset = rstTicks;
        clampTicks  = 8'd1;
        sampleDelay = CW'((p >= 4) ? p - 4 : 0);
        lineClamp   = (cm != 0);
        clampHold   = (cm == 2);
        leadTicks   = CW'(1 + p % 3);
        sgTicks     = 8'd4;
        trailTicks  = CW'(1 + p % 2);
        swDelay     = CW'(1 + p % 2);
        colorMode   = (p % 2) == 1;
        runLines(2);
      end
    end
    // R11: run enable dropped mid-line
    scen = "R11";
    repeat (4) tick();
    runEn = 1'b0;
    while (!mIdle) tick();
    repeat (10) tick();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule